// File: doc/BRIEF.md
# Quad Double-Buffered Converter Code Registers

This block is the digital front end of a four-channel, 16-bit converter. An external controller works over a small parallel bus. The bus has a two-bit channel address, a read/write select, an active-low chip select and a shared bidirectional 16-bit data port. Through it the controller fills or reads back one staging register per channel. A separate load strobe moves all four staged codes into the live code registers in one step, so the four converter cores always change together.

All bus and strobe pins are brought into the system clock domain through a short synchronizer chain. A registered edge detector then finds the rising edges of chip select and load. Reset is asynchronous and active low. While it is asserted, both ranks of every channel are forced to zero code or to midscale, as chosen by a select pin.

Top module: `quad_dac_regs`

## Requirements
- R1: While `rst_ni` is low and `rst_sel_i` is low, every staging register and every live code reads 0x0000.
- R2: While `rst_ni` is low and `rst_sel_i` is high, every staging register and every live code reads 0x8000.
- R3: A rising edge of `cs_ni` while `rd_wr_i` is low (write) stores `data_io` into the staging register addressed by `addr_i` (0 = A, 1 = B, 2 = C, 3 = D). The other three staging registers keep their values.
- R4: While `cs_ni` is low and `rd_wr_i` is high, `data_io` carries the staging register addressed by `addr_i`. Otherwise the block leaves `data_io` at high impedance.
- R5: Writes to staging registers leave `codes_o` unchanged until the next rising edge of `load_i`.
- R6: A rising edge of `load_i` copies all four staging registers into the live codes together. A held-high or falling `load_i` copies nothing. Channel k appears on `codes_o[16k+15:16k]`.
- R7: When a write edge and a load edge are detected in the same clock cycle, the live code takes the staging value from before that write.
- R8: The full code range passes unchanged, including 0x0000 and 0xFFFF.
- R9: Reset acts without a clock edge. It overrides writes and loads for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_sel_i | input | 1 | Reset target: 0 zero code, 1 midscale |
| cs_ni | input | 1 | Active-low chip select; its rising edge commits a write |
| rd_wr_i | input | 1 | 1 read, 0 write |
| addr_i | input | 2 | Channel address (0..3 = A..D) |
| data_io | inout | 16 | Bidirectional data port |
| load_i | input | 1 | Load strobe; its rising edge updates all channels |
| codes_o | output | 64 | Live codes, channel k at bits 16k+15:16k |

## Verification
A write commit and a load update can fall in the same clock cycle. The bench provokes this by raising `cs_ni` and `load_i` on the same falling clock edge. Both pins pass through equal synchronizer latency, so the two edges are detected together. It then judges the result: the live code must still show the earlier staged value, read-back must already show the new one, and a second load must then carry the new value through.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int unsigned CODE_W  = 16;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned SYNC_N  = 2;

  typedef enum logic {
    RST_ZERO = 1'b0,
    RST_MID  = 1'b1
  } rst_kind_e;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d_i;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rst_code_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         load_i,
  output logic [W-1:0] in_o,
  output logic [W-1:0] out_o
);
  logic [W-1:0] in_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= rst_code_i;
      out_q <= rst_code_i;
    end else begin
      if (wr_en_i) in_q  <= wr_data_i;
      if (load_i)  out_q <= in_q;  // old staged value on a same-cycle write
    end
  end

  assign in_o  = in_q;
  assign out_o = out_q;

  p_wr_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> in_q == $past(wr_data_i));
  p_in_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(in_q));
  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(out_q));
  // R6 and R7: live code takes the staged value seen before the edge
  p_load_copy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> out_q == $past(in_q));
endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs #(
  parameter  int unsigned DATA_W      = dac_pkg::CODE_W,
  parameter  int unsigned NUM_CH      = dac_pkg::NUM_CH,
  parameter  int unsigned SYNC_STAGES = dac_pkg::SYNC_N,
  localparam int unsigned ADDR_W      = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rst_sel_i,
  input  logic                     cs_ni,
  input  logic                     rd_wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  inout  wire  [DATA_W-1:0]        data_io,
  input  logic                     load_i,
  output logic [NUM_CH*DATA_W-1:0] codes_o
);
  localparam int unsigned BUS_W = DATA_W + ADDR_W + 3;
  localparam logic [BUS_W-1:0] BUS_IDLE = {3'b111, {(ADDR_W+DATA_W){1'b0}}};
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] rst_code;
  assign rst_code = (dac_pkg::rst_kind_e'(rst_sel_i) == dac_pkg::RST_MID) ? MID_CODE : '0;

  // bus into the clock domain: {load, cs_n, rd_wr, addr, data}
  logic [BUS_W-1:0]  bus_s;
  logic              ld_s, cs_s, rw_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  dac_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({load_i, cs_ni, rd_wr_i, addr_i, data_io}),
    .q_o    (bus_s)
  );
  assign {ld_s, cs_s, rw_s, addr_s, data_s} = bus_s;

  // registered edge detect; idle-high history blocks false edges after reset
  logic cs_prev, ld_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev <= 1'b1;
      ld_prev <= 1'b1;
    end else begin
      cs_prev <= cs_s;
      ld_prev <= ld_s;
    end
  end

  logic ld_rise, wr_fire;
  assign ld_rise = ld_s & ~ld_prev;
  assign wr_fire = cs_s & ~cs_prev & ~rw_s;

  logic [DATA_W-1:0] in_q [NUM_CH];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic wr_en;
    assign wr_en = wr_fire && (addr_s == ADDR_W'(k));

    dac_chan #(.W(DATA_W)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rst_code_i (rst_code),
      .wr_en_i    (wr_en),
      .wr_data_i  (data_s),
      .load_i     (ld_rise),
      .in_o       (in_q[k]),
      .out_o      (codes_o[k*DATA_W +: DATA_W])
    );
  end

  // read-back path is combinational from the pins
  assign data_io = (!cs_ni && rd_wr_i) ? in_q[addr_i] : {DATA_W{1'bz}};

  p_load_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rise |=> !ld_rise);
endmodule

// File: tb/test_quad_dac_regs.sv
`timescale 1ns/1ps
module test_quad_dac_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_sel = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_wr = 1'b1;
  logic [1:0]  addr = '0;
  logic        load = 1'b0;
  logic        tb_oe = 1'b0;
  logic [15:0] tb_d = '0;
  wire  [15:0] bus;
  logic [63:0] codes;

  logic [15:0] exp_in  [4];
  logic [15:0] exp_out [4];
  int n_chk = 0;
  int n_fail = 0;

  assign bus = tb_oe ? tb_d : 16'hzzzz;

  always #2.5 clk = ~clk;

  quad_dac_regs i_quad_dac_regs (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .rst_sel_i (rst_sel),
    .cs_ni     (cs_n),
    .rd_wr_i   (rd_wr),
    .addr_i    (addr),
    .data_io   (bus),
    .load_i    (load),
    .codes_o   (codes)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_codes(input string tag);
    for (int k = 0; k < 4; k++) chk(tag, codes[k*16 +: 16], exp_out[k]);
  endtask

  task automatic bus_write(input int ch, input logic [15:0] v);
    @(negedge clk);
    addr = 2'(ch); rd_wr = 1'b0; tb_d = v; tb_oe = 1'b1; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    tb_oe = 1'b0; rd_wr = 1'b1;
    if (rst_ni) exp_in[ch] = v;
  endtask

  task automatic pulse_load();
    @(negedge clk);
    load = 1'b1;
    repeat (4) @(negedge clk);
    load = 1'b0;
    repeat (4) @(negedge clk);
    if (rst_ni) for (int k = 0; k < 4; k++) exp_out[k] = exp_in[k];
  endtask

  task automatic read_chk(input string tag, input int ch);
    @(negedge clk);
    addr = 2'(ch); rd_wr = 1'b1; cs_n = 1'b0;
    #1 chk(tag, bus, exp_in[ch]);
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic t_reset_zero();
    for (int k = 0; k < 4; k++) begin exp_in[k] = 16'h0000; exp_out[k] = 16'h0000; end
    repeat (3) @(negedge clk);
    chk_codes("R1 zero reset codes");
    for (int k = 0; k < 4; k++) read_chk("R1 zero reset readback", k);
    @(negedge clk) rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk_codes("R1 after release");
  endtask

  task automatic t_write_hold();
    bus_write(0, 16'h1234); bus_write(1, 16'hA5A5);
    bus_write(2, 16'h0F0F); bus_write(3, 16'h7001);
    chk_codes("R5 codes held after writes");
    for (int k = 0; k < 4; k++) read_chk("R3 readback", k);
    bus_write(2, 16'h3C3C);
    read_chk("R3 rewrite C", 2);
    read_chk("R3 neighbour B kept", 1);
    read_chk("R3 neighbour D kept", 3);
  endtask

  task automatic t_load();
    pulse_load();
    chk_codes("R6 load copies all");
    @(negedge clk) load = 1'b1;
    repeat (4) @(negedge clk);
    chk_codes("R6 rising edge while level held");
    bus_write(0, 16'h4444);
    chk_codes("R6 held level no copy");
    @(negedge clk) load = 1'b0;
    repeat (4) @(negedge clk);
    chk_codes("R6 falling edge no copy");
    pulse_load();
    chk("R6 new A after edge", codes[15:0], 16'h4444);
  endtask

  task automatic t_extremes();
    bus_write(1, 16'hFFFF); bus_write(2, 16'h0000);
    read_chk("R8 readback FFFF", 1);
    pulse_load();
    chk("R8 code FFFF", codes[31:16], 16'hFFFF);
    chk("R8 code 0000", codes[47:32], 16'h0000);
  endtask

  task automatic t_bus_z();
    @(negedge clk);
    cs_n = 1'b1; rd_wr = 1'b1;
    #1 chk("R4 z when deselected", bus, 16'hzzzz);
    @(negedge clk);
    cs_n = 1'b0; rd_wr = 1'b0;
    #1 chk("R4 z during write", bus, 16'hzzzz);
    @(negedge clk);
    cs_n = 1'b1; rd_wr = 1'b1;
    read_chk("R4 driven on read", 3);
  endtask

  task automatic t_collide();
    bus_write(0, 16'h1111);
    pulse_load();
    @(negedge clk);
    addr = 2'd0; rd_wr = 1'b0; tb_d = 16'h2222; tb_oe = 1'b1; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; load = 1'b1;
    repeat (4) @(negedge clk);
    load = 1'b0; tb_oe = 1'b0; rd_wr = 1'b1;
    repeat (4) @(negedge clk);
    exp_in[0] = 16'h2222;
    chk("R7 live code keeps old", codes[15:0], 16'h1111);
    read_chk("R7 staging has new", 0);
    pulse_load();
    chk("R7 next load passes new", codes[15:0], 16'h2222);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_sel = 1'b1; rst_ni = 1'b0;
    for (int k = 0; k < 4; k++) begin exp_in[k] = 16'h8000; exp_out[k] = 16'h8000; end
    #1 chk_codes("R9 async midscale");
    bus_write(1, 16'h5555);
    pulse_load();
    chk_codes("R9 load ignored in reset");
    read_chk("R9 write ignored in reset", 1);
    read_chk("R2 midscale readback", 3);
    @(negedge clk) rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk_codes("R2 midscale after release");
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_zero();
    t_write_hold();
    t_load();
    t_extremes();
    t_bus_z();
    t_collide();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule